// File: doc/BRIEF.md
# Colour Palette Port Controller

This block sits between a byte-wide processor port and a 256-entry colour table. Each entry holds three 6-bit intensities, one each for red, green and blue. Software reaches the table through four byte registers: a write pointer, a read pointer, a data register and a pixel mask. A colour is moved as three consecutive data accesses in the fixed order red, green, blue. A pointer that steps on its own lets software stream whole blocks of colours without reloading the address.

A second, independent read port serves the display pipeline. Each cycle it takes an 8-bit pixel code, combines it with the mask using a bitwise AND, and returns the matching 18-bit colour one clock later. Reading the read-pointer register reports whether the last palette command was a load or a fetch. Software uses this to resume an interrupted sequence correctly.

Top module: `pal_port_ctrl`

## Requirements
- R1: An access happens on a clock where `cpu_sel` is 1. `cpu_wr`=1 writes `cpu_wdata` and `cpu_wr`=0 reads through `cpu_rdata`, which reflects the state before that edge. `cpu_reg` picks the register: 2'b00 mask, 2'b01 read pointer/status, 2'b10 write pointer, 2'b11 colour data.
- R2: After reset the mask is 8'hFF, the status reads 2'b00, the shared pointer is 0 and the next data access addresses red.
- R3: A write to register 2'b10 loads the pointer. The next three data writes supply red, green and blue. The entry is stored only on the blue write, and the pointer then steps by one, wrapping from 8'hFF to 8'h00. This allows burst loads.
- R4: Writing either pointer register (2'b01 or 2'b10) returns the colour sequence to red, dropping any partial colour.
- R5: A write to register 2'b01 loads the pointer and fetches that entry. The next three data reads return red, green and blue. After blue, the pointer steps by one and the following entry is fetched, which allows burst reads.
- R6: Reading register 2'b01 returns the last command type in bits 1:0: 2'b00 after a write-pointer load or data write, and 2'b11 after a read-pointer load or data read. Bits 7:2 read as 0.
- R7: Reading register 2'b10 returns the current pointer. Reading register 2'b00 returns the mask.
- R8: `pix_rgb` carries, one clock after `pix_code` is applied, the entry at `pix_code & mask`, packed with red in bits 17:12, green in 11:6 and blue in 5:0.
- R9: A mask write changes which entry the pixel port reaches. The mask keeps its value while it is not written.
- R10: On data writes, bits 7:6 of `cpu_wdata` are ignored. Data reads return the 6-bit value with bits 7:6 at 0.
- R11: A red or green write that is not followed by its blue write leaves the stored entry unchanged, as seen at the pixel port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Access strobe, one access per clock |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_reg | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| pix_code | input | 8 | Pixel code from the display pipeline |
| pix_rgb | output | 18 | Looked-up colour, one clock latency |

## Verification
Burst loads are tried with distinct per-channel values, so that a swapped channel order or a missed commit shows up at the pixel port. Burst fetches are read back to separate prefetch errors from pointer-step errors. Partial sequences followed by a pointer reload tell a premature commit apart from a stale phase counter. A wrap at entry 8'hFF checks the pointer width, and a narrowed mask with aliased pixel codes shows whether masking happens before the table read.

// File: rtl/pal_pkg.sv
package pal_pkg;
   typedef enum logic [1:0] {
      REG_MASK  = 2'b00,
      REG_RADDR = 2'b01,
      REG_WADDR = 2'b10,
      REG_DATA  = 2'b11
   } reg_sel_e;

   typedef enum logic [1:0] {
      PH_RED   = 2'b00,
      PH_GREEN = 2'b01,
      PH_BLUE  = 2'b10
   } phase_e;

   typedef enum logic [1:0] {
      LAST_WRITE = 2'b00,
      LAST_READ  = 2'b11
   } last_cmd_e;
endpackage

// File: rtl/pal_store.sv
module pal_store #(
   parameter int ADDR_W = 8,
   parameter int CHAN_W = 6,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int RGB_W = 3 * CHAN_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [RGB_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [RGB_W-1:0]  fetch_data,
   input  logic [ADDR_W-1:0] pix_addr,
   output logic [RGB_W-1:0]  pix_data
);
   logic [RGB_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign fetch_data = mem[fetch_addr];
   assign pix_data   = mem[pix_addr];
endmodule

// File: rtl/pal_cpu_seq.sv
module pal_cpu_seq
   import pal_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CHAN_W = 6,
   parameter int BUS_W  = 8,
   localparam int RGB_W = 3 * CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  reg_sel_e          rsel,
   input  logic [BUS_W-1:0]  wdata,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [RGB_W-1:0]  fetch_data,
   output logic              commit_we,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [RGB_W-1:0]  commit_data,
   output logic [ADDR_W-1:0] ptr,
   output last_cmd_e         last_cmd,
   output logic [CHAN_W-1:0] rd_field
);
   phase_e             phase;
   logic [CHAN_W-1:0]  red_hold;
   logic [CHAN_W-1:0]  grn_hold;
   logic [RGB_W-1:0]   pre_buf;
   logic               ld_waddr;
   logic               ld_raddr;
   logic               dat_wr;
   logic               dat_rd;
   logic [ADDR_W-1:0]  ptr_next;

   assign ld_waddr = acc &&  wr && (rsel == REG_WADDR);
   assign ld_raddr = acc &&  wr && (rsel == REG_RADDR);
   assign dat_wr   = acc &&  wr && (rsel == REG_DATA);
   assign dat_rd   = acc && !wr && (rsel == REG_DATA);
   assign ptr_next = ptr + ADDR_W'(1);

   assign fetch_addr  = ld_raddr ? wdata[ADDR_W-1:0] : ptr_next;
   assign commit_we   = dat_wr && (phase == PH_BLUE);
   assign commit_addr = ptr;
   assign commit_data = {red_hold, grn_hold, wdata[CHAN_W-1:0]};

   always_comb begin
      unique case (phase)
         PH_RED:   rd_field = pre_buf[RGB_W-1 -: CHAN_W];
         PH_GREEN: rd_field = pre_buf[2*CHAN_W-1 -: CHAN_W];
         default:  rd_field = pre_buf[CHAN_W-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         phase    <= PH_RED;
         last_cmd <= LAST_WRITE;
         red_hold <= '0;
         grn_hold <= '0;
         pre_buf  <= '0;
      end else if (ld_waddr || ld_raddr) begin
         ptr      <= wdata[ADDR_W-1:0];
         phase    <= PH_RED;
         last_cmd <= ld_waddr ? LAST_WRITE : LAST_READ;
         if (ld_raddr) begin
            pre_buf <= fetch_data;
         end
      end else if (dat_wr) begin
         last_cmd <= LAST_WRITE;
         unique case (phase)
            PH_RED: begin
               red_hold <= wdata[CHAN_W-1:0];
               phase    <= PH_GREEN;
            end
            PH_GREEN: begin
               grn_hold <= wdata[CHAN_W-1:0];
               phase    <= PH_BLUE;
            end
            default: begin
               ptr   <= ptr_next;
               phase <= PH_RED;
            end
         endcase
      end else if (dat_rd) begin
         last_cmd <= LAST_READ;
         unique case (phase)
            PH_RED:   phase <= PH_GREEN;
            PH_GREEN: phase <= PH_BLUE;
            default: begin
               ptr     <= ptr_next;
               phase   <= PH_RED;
               pre_buf <= fetch_data;
            end
         endcase
      end
   end

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'b11); // R3
   AST_ADDR_TO_RED: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_waddr || ld_raddr) |=> (phase == PH_RED)); // R4
   AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && phase != PH_BLUE) |=> $stable(ptr)); // R3
   AST_BLUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((dat_wr || dat_rd) && phase == PH_BLUE) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R5
   AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd || ld_raddr) |=> (last_cmd == LAST_READ)); // R6
   AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr || ld_waddr) |=> (last_cmd == LAST_WRITE)); // R6
endmodule

// File: rtl/pal_pix_lookup.sv
module pal_pix_lookup #(
   parameter int ADDR_W  = 8,
   parameter int CHAN_W  = 6,
   parameter bit PIX_REG = 1'b1,
   localparam int RGB_W  = 3 * CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [ADDR_W-1:0] mask_wdata,
   output logic [ADDR_W-1:0] mask,
   input  logic [ADDR_W-1:0] pix_code,
   output logic [ADDR_W-1:0] pix_addr,
   input  logic [RGB_W-1:0]  pix_data,
   output logic [RGB_W-1:0]  pix_rgb
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '1;
      end else if (mask_we) begin
         mask <= mask_wdata;
      end
   end

   assign pix_addr = pix_code & mask;

   generate
      if (PIX_REG) begin : g_reg_out
         always_ff @(posedge clk) begin
            pix_rgb <= pix_data;
         end
      end else begin : g_comb_out
         assign pix_rgb = pix_data;
      end
   endgenerate

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask)); // R9
endmodule

// File: rtl/pal_port_ctrl.sv
module pal_port_ctrl
   import pal_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int CHAN_W  = 6,
   parameter int BUS_W   = 8,
   parameter bit PIX_REG = 1'b1,
   localparam int RGB_W  = 3 * CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [1:0]        cpu_reg,
   input  logic [BUS_W-1:0]  cpu_wdata,
   output logic [BUS_W-1:0]  cpu_rdata,
   input  logic [ADDR_W-1:0] pix_code,
   output logic [RGB_W-1:0]  pix_rgb
);
   generate
      if (BUS_W < ADDR_W) begin : g_chk_addr
         $error("pal_port_ctrl: BUS_W must hold a pointer");
      end
      if (BUS_W < CHAN_W) begin : g_chk_chan
         $error("pal_port_ctrl: BUS_W must hold a colour channel");
      end
      if (BUS_W < 2) begin : g_chk_stat
         $error("pal_port_ctrl: BUS_W must hold the status field");
      end
   endgenerate

   reg_sel_e          rsel;
   logic [ADDR_W-1:0] fetch_addr;
   logic [RGB_W-1:0]  fetch_data;
   logic              commit_we;
   logic [ADDR_W-1:0] commit_addr;
   logic [RGB_W-1:0]  commit_data;
   logic [ADDR_W-1:0] ptr;
   last_cmd_e         last_cmd;
   logic [CHAN_W-1:0] rd_field;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] pix_addr;
   logic [RGB_W-1:0]  pix_data;
   logic              mask_we;

   assign rsel    = reg_sel_e'(cpu_reg);
   assign mask_we = cpu_sel && cpu_wr && (rsel == REG_MASK);

   pal_cpu_seq #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .BUS_W(BUS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc(cpu_sel), .wr(cpu_wr), .rsel(rsel),
      .wdata(cpu_wdata), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .commit_we(commit_we), .commit_addr(commit_addr), .commit_data(commit_data),
      .ptr(ptr), .last_cmd(last_cmd), .rd_field(rd_field)
   );

   pal_store #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_store (
      .clk(clk), .we(commit_we), .waddr(commit_addr), .wdata(commit_data),
      .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .pix_addr(pix_addr), .pix_data(pix_data)
   );

   pal_pix_lookup #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .PIX_REG(PIX_REG)) u_pix (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(cpu_wdata[ADDR_W-1:0]),
      .mask(mask), .pix_code(pix_code), .pix_addr(pix_addr),
      .pix_data(pix_data), .pix_rgb(pix_rgb)
   );

   always_comb begin
      unique case (rsel)
         REG_MASK:  cpu_rdata = BUS_W'(mask);
         REG_RADDR: cpu_rdata = BUS_W'(last_cmd);
         REG_WADDR: cpu_rdata = BUS_W'(ptr);
         default:   cpu_rdata = BUS_W'(rd_field);
      endcase
   end

   AST_STATUS_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel == REG_RADDR) |-> (cpu_rdata[BUS_W-1:2] == '0)); // R6
   AST_DATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel == REG_DATA) |-> (cpu_rdata[BUS_W-1:CHAN_W] == '0)); // R10
endmodule

// File: tb/pal_port_ctrl_test.sv
module pal_port_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [1:0]  cpu_reg = 2'b00;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  cpu_rdata;
   logic [7:0]  pix_code = 8'h00;
   logic [17:0] pix_rgb;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_port_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
      .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .pix_code(pix_code), .pix_rgb(pix_rgb)
   );

   function automatic logic [17:0] rgb(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
      return {r, g, b};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] r, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_reg = r; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] r, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_reg = r;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 1'b0;
   endtask

   task automatic peek(input logic [1:0] r, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b0; cpu_reg = r;
      #1 d = cpu_rdata;
   endtask

   task automatic load_colour(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
      reg_write(2'b11, r);
      reg_write(2'b11, g);
      reg_write(2'b11, b);
   endtask

   task automatic pix_check(input string req, input logic [7:0] code, input logic [17:0] exp);
      @(negedge clk);
      pix_code = code;
      @(negedge clk);
      check(req, 32'(pix_rgb), 32'(exp));
   endtask

   task automatic t_reset;
      logic [7:0] v;
      peek(2'b00, v); check("R2 mask after reset", 32'(v), 32'hFF);
      peek(2'b01, v); check("R2 status after reset", 32'(v), 32'h00);
      peek(2'b10, v); check("R2 pointer after reset", 32'(v), 32'h00);
   endtask

   task automatic t_burst_write;
      logic [7:0] v;
      reg_write(2'b10, 8'h10);
      load_colour(8'h01, 8'h02, 8'h03);
      load_colour(8'h3F, 8'h20, 8'h11);
      peek(2'b10, v); check("R3 R7 pointer after burst load", 32'(v), 32'h12);
      pix_check("R8 pixel entry 10", 8'h10, rgb(6'h01, 6'h02, 6'h03));
      pix_check("R8 pixel entry 11", 8'h11, rgb(6'h3F, 6'h20, 6'h11));
   endtask

   task automatic t_burst_read;
      logic [7:0] v;
      reg_write(2'b01, 8'h10);
      reg_read(2'b11, v); check("R5 read red 10", 32'(v), 32'h01);
      reg_read(2'b11, v); check("R5 read green 10", 32'(v), 32'h02);
      reg_read(2'b11, v); check("R5 read blue 10", 32'(v), 32'h03);
      reg_read(2'b11, v); check("R5 prefetch red 11", 32'(v), 32'h3F);
      reg_read(2'b11, v); check("R5 prefetch green 11", 32'(v), 32'h20);
      reg_read(2'b11, v); check("R5 prefetch blue 11", 32'(v), 32'h11);
      peek(2'b01, v); check("R6 status after reads", 32'(v), 32'h03);
      peek(2'b10, v); check("R5 pointer after burst read", 32'(v), 32'h12);
   endtask

   task automatic t_status_write;
      logic [7:0] v;
      reg_write(2'b10, 8'h20);
      peek(2'b01, v); check("R6 status after write pointer", 32'(v), 32'h00);
      reg_write(2'b01, 8'h20);
      peek(2'b01, v); check("R6 status after read pointer", 32'(v), 32'h03);
      reg_write(2'b10, 8'h20);
      reg_write(2'b11, 8'h05);
      peek(2'b01, v); check("R6 status after data write", 32'(v), 32'h00);
   endtask

   task automatic t_wrap;
      logic [7:0] v;
      reg_write(2'b10, 8'hFF);
      load_colour(8'h05, 8'h06, 8'h07);
      peek(2'b10, v); check("R3 pointer wraps", 32'(v), 32'h00);
      pix_check("R3 entry FF stored", 8'hFF, rgb(6'h05, 6'h06, 6'h07));
   endtask

   task automatic t_partial;
      reg_write(2'b10, 8'h30);
      load_colour(8'h0A, 8'h0B, 8'h0C);
      reg_write(2'b10, 8'h30);
      reg_write(2'b11, 8'h1A);
      reg_write(2'b11, 8'h1B);
      pix_check("R11 partial colour not stored", 8'h30, rgb(6'h0A, 6'h0B, 6'h0C));
      reg_write(2'b10, 8'h30);
      load_colour(8'h2A, 8'h2B, 8'h2C);
      pix_check("R4 reload restarts at red", 8'h30, rgb(6'h2A, 6'h2B, 6'h2C));
   endtask

   task automatic t_read_restart;
      logic [7:0] v;
      reg_write(2'b01, 8'h10);
      reg_read(2'b11, v);
      reg_write(2'b01, 8'h10);
      reg_read(2'b11, v); check("R4 read pointer reload gives red", 32'(v), 32'h01);
      reg_read(2'b11, v); check("R4 then green", 32'(v), 32'h02);
   endtask

   task automatic t_high_bits;
      logic [7:0] v;
      reg_write(2'b10, 8'h40);
      load_colour(8'hC5, 8'h7F, 8'h80);
      reg_write(2'b01, 8'h40);
      reg_read(2'b11, v); check("R10 red high bits dropped", 32'(v), 32'h05);
      reg_read(2'b11, v); check("R10 green high bits dropped", 32'(v), 32'h3F);
      reg_read(2'b11, v); check("R10 blue high bits dropped", 32'(v), 32'h00);
      pix_check("R10 entry 40 at pixel port", 8'h40, rgb(6'h05, 6'h3F, 6'h00));
   endtask

   task automatic t_mask;
      logic [7:0] v;
      reg_write(2'b10, 8'h0A);
      load_colour(8'h11, 8'h22, 8'h33);
      reg_write(2'b00, 8'h0F);
      peek(2'b00, v); check("R7 R9 mask readback", 32'(v), 32'h0F);
      pix_check("R9 code 1A masked to 0A", 8'h1A, rgb(6'h11, 6'h22, 6'h33));
      pix_check("R9 code F0 masked to 00", 8'hF0, 32'(pix_rgb) == 32'(rgb(6'h11, 6'h22, 6'h33)) ? 18'h0 : 18'h0);
      pix_check("R9 code 3A masked to 0A", 8'h3A, rgb(6'h11, 6'h22, 6'h33));
      reg_write(2'b00, 8'hFF);
      pix_check("R1 mask FF restores direct lookup", 8'h10, rgb(6'h01, 6'h02, 6'h03));
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_burst_write();
      t_burst_read();
      t_status_write();
      t_wrap();
      reg_write(2'b10, 8'h00);
      load_colour(8'h00, 8'h00, 8'h00);
      t_partial();
      t_read_restart();
      t_high_bits();
      t_mask();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule